// File: doc/BRIEF.md
# Stereo Serial Audio Data Port

This block sits between a codec core and a host serial port and moves stereo samples both ways over one bit clock, one word clock or frame-sync line, and one data line in each direction. The block is always a slave. It samples the host's bit clock and word clock with its own system clock, shifts receive data in on rising bit-clock edges, and drives transmit data on falling edges.

Two framings are supported and selected by `mode_i`. In DSP framing (`mode_i` = 0) a one-bit-clock frame-sync pulse opens three back-to-back slots. Inbound they carry a control word, then the left DAC sample, then the right DAC sample. Outbound they carry the status word, then the left ADC sample, then the right ADC sample. In I2S-style framing (`mode_i` = 1) the word-clock level names the channel, and each word starts one bit clock after the word clock changes. Once the right word of a frame has arrived, the left sample, the right sample and the control word are presented together with a one-cycle strobe.

A sequencer with four states drives the port. IDLE waits for a start. ARMED waits for the falling edge that puts the first bit of a word on the line. DATA shifts the significant bits. PAD covers the trailing bit clocks of a slot. The transitions are:
- IDLE→ARMED on a start: a frame-sync pulse, or a change of the word clock.
- ARMED→DATA on the next falling edge.
- DATA→PAD after the last significant bit.
- DATA/PAD→ARMED at the end of the control or left slot in DSP framing.
- DATA/PAD→IDLE after the right slot in DSP framing.
- PAD→PAD (holding) in I2S framing until the next word-clock change.
- Any state→ARMED whenever a start is seen.

Top module: `audio_serial_port`

## Requirements
- R1: Reset state. After reset `sdout_o` is 0, `dac_left_o`, `dac_right_o` and `ctrl_o` are all zero, and `dac_valid_o` stays low until a frame completes.
- R2: DSP framing, inbound. With `mode_i` = 0, a frame starts when `wsync_i` is high at a rising bit-clock edge. Each of the following three slots spans SLOT_W (24) bit clocks, and the slot bits begin at the next rising edge. The slots carry, in order, the control word (`ctrl_o`), the left sample (`dac_left_o`) and the right sample (`dac_right_o`).
- R3: DSP framing, outbound. The slots start at the same bit positions and carry, in order, `status_i`, `adc_left_i` and `adc_right_i`.
- R4: Word length. `wlen_i` selects 00=16, 01=18, 10=20 or 11=24 bits. Words travel MSB first. Parallel words are right-aligned: bits [w-1:0] carry the sample, and the upper bits of every parallel output are zero. Upper bits of a parallel input are not transmitted.
- R5: Trailing bit clocks. Bit clocks past the word length in a slot drive 0 on `sdout_o`, and any data received in those positions is ignored.
- R6: I2S framing. With `mode_i` = 1, `wsync_i` low marks the left word and high marks the right word. When a change of `wsync_i` is seen at a rising edge, the bit sampled at that edge still belongs to the old word, and the new word's MSB follows at the next rising edge.
- R7: Edges. `sdout_o` changes only after falling bit-clock edges and holds through the high phase. `sdin_i` is sampled at rising edges.
- R8: Commit. `dac_left_o`, `dac_right_o` and `ctrl_o` update in the same cycle as a single-cycle `dac_valid_o` pulse. This happens once per frame, when the last significant bit of the right word is captured, and never earlier.
- R9: I2S frames leave `ctrl_o` at the value from the last DSP frame.
- R10: When the I2S half-frame equals the word length, the LSB of one word and the start of the next fall on the same rising edge. Both words are still received and sent intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk_i | input | 1 | Host bit clock |
| wsync_i | input | 1 | Word clock (I2S) or frame sync (DSP) |
| sdin_i | input | 1 | Serial data from host |
| mode_i | input | 1 | 0 = DSP framing, 1 = I2S framing |
| wlen_i | input | 2 | Word length select |
| adc_left_i | input | SLOT_W | Left ADC sample to send |
| adc_right_i | input | SLOT_W | Right ADC sample to send |
| status_i | input | SLOT_W | Status word to send (DSP framing) |
| sdout_o | output | 1 | Serial data to host |
| dac_left_o | output | SLOT_W | Received left sample |
| dac_right_o | output | SLOT_W | Received right sample |
| ctrl_o | output | SLOT_W | Received control word |
| dac_valid_o | output | 1 | One-cycle strobe for a new sample set |

## Verification
The receive side can finish a word and the framing logic can open a new word on the same rising bit-clock edge. Each of the two events also decides the state of the word-assembly register, so their order matters. This coincidence is provoked with I2S frames whose half-frame length equals the word length, so the word clock changes at the very edge that samples each LSB. It is judged by comparing both received words and both transmitted words against the driven and parallel values. A further check confirms that the outputs did not move before the right word's LSB.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DATA  = 2'd2,
        ST_PAD   = 2'd3
    } sap_state_e;

    typedef enum logic [1:0] {
        SL_CMD   = 2'd0,
        SL_LEFT  = 2'd1,
        SL_RIGHT = 2'd2
    } sap_slot_e;

    localparam logic MODE_DSP = 1'b0;

    // word length in bit clocks for the 2-bit select
    function automatic logic [4:0] wlen_bits(input logic [1:0] sel);
        logic [4:0] n;
        case (sel)
            2'b00:   n = 5'd16;
            2'b01:   n = 5'd18;
            2'b10:   n = 5'd20;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic fall_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int LAST = STAGES - 1;

    logic [2:0] stg [STAGES];
    logic       bclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            bclk_d <= 1'b0;
        end else begin
            stg[0] <= {bclk_i, ws_i, sd_i};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            bclk_d <= stg[LAST][2];
        end
    end

    // word clock and data come from the same stage as the bit clock
    assign rise_o = stg[LAST][2] & ~bclk_d;
    assign fall_o = ~stg[LAST][2] & bclk_d;
    assign ws_o   = stg[LAST][1];
    assign sd_o   = stg[LAST][0];

endmodule

// File: rtl/sap_seq.sv
module sap_seq
    import sap_pkg::*;
#(
    parameter int SLOT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       ws_i,
    input  logic       dsp_i,
    input  logic [4:0] wbits_i,
    output sap_slot_e  slot_o,
    output logic       cap_o,
    output logic       done_o,
    output logic       begin_o,
    output logic       load_o,
    output logic       shift_o
);
    localparam int POS_W = $clog2(SLOT_W);
    localparam logic [POS_W-1:0] POS_END = POS_W'(SLOT_W - 1);

    sap_state_e       st, st_n;
    sap_slot_e        slot, slot_n;
    logic [POS_W-1:0] pos, pos_n;
    logic             ws_prev;
    logic             start, adv, last_bit, slot_end;

    assign start    = rise_i & (dsp_i ? ws_i : (ws_i ^ ws_prev));
    assign last_bit = (pos == POS_W'(wbits_i - 5'd1));
    assign slot_end = (pos == POS_END);

    always_comb begin
        st_n   = st;
        slot_n = slot;
        pos_n  = pos;
        adv    = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ARMED: begin
                if (fall_i) st_n = ST_DATA;
            end
            ST_DATA, ST_PAD: begin
                if (rise_i) begin
                    if (st == ST_DATA && last_bit) st_n = ST_PAD;
                    if (!slot_end) begin
                        pos_n = pos + POS_W'(1);
                    end else if (dsp_i) begin
                        if (slot == SL_RIGHT) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n   = ST_ARMED;
                            slot_n = sap_slot_e'(slot + 2'd1);
                            pos_n  = '0;
                            adv    = 1'b1;
                        end
                    end else begin
                        st_n = ST_PAD;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (start) begin
            st_n   = ST_ARMED;
            pos_n  = '0;
            slot_n = dsp_i ? SL_CMD : (ws_i ? SL_RIGHT : SL_LEFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            slot    <= SL_CMD;
            pos     <= '0;
            ws_prev <= 1'b0;
        end else begin
            st   <= st_n;
            slot <= slot_n;
            pos  <= pos_n;
            if (rise_i) ws_prev <= ws_i;
        end
    end

    always_comb begin
        slot_o  = slot;
        cap_o   = rise_i & (st == ST_DATA);
        done_o  = rise_i & (st == ST_DATA) & last_bit;
        begin_o = start | adv;
        load_o  = fall_i & (st == ST_ARMED);
        shift_o = fall_i & (st == ST_DATA);
    end

    // R5: bit position never leaves the slot
    a_r5_pos_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_END);
    // R2: only three slots exist
    a_r2_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        slot != sap_slot_e'(2'd3));
    // R6: a start always arms the next word
    a_r6_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == ST_ARMED));

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int SLOT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              done_i,
    input  logic              begin_i,
    input  logic              sd_i,
    input  sap_slot_e         slot_i,
    input  logic [4:0]        wbits_i,
    output logic [SLOT_W-1:0] dac_left_o,
    output logic [SLOT_W-1:0] dac_right_o,
    output logic [SLOT_W-1:0] ctrl_o,
    output logic              valid_o
);
    logic [SLOT_W-1:0] rx, rx_n, left_h, ctl_h;

    assign rx_n = {rx[SLOT_W-2:0], sd_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx          <= '0;
            left_h      <= '0;
            ctl_h       <= '0;
            dac_left_o  <= '0;
            dac_right_o <= '0;
            ctrl_o      <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (begin_i)    rx <= '0;
            else if (cap_i) rx <= rx_n;
            if (done_i) begin
                unique case (slot_i)
                    SL_CMD:   ctl_h  <= rx_n;
                    SL_LEFT:  left_h <= rx_n;
                    SL_RIGHT: begin
                        dac_left_o  <= left_h;
                        dac_right_o <= rx_n;
                        ctrl_o      <= ctl_h;
                        valid_o     <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: strobe lasts one cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R8: outputs move only with the strobe
    a_r8_joint_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_left_o) || !$stable(dac_right_o) || !$stable(ctrl_o)) |-> valid_o);
    // R4: committed right sample is right-aligned
    a_r4_right_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((dac_right_o >> wbits_i) == '0));

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SLOT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  sap_slot_e         slot_i,
    input  logic [4:0]        wbits_i,
    input  logic [SLOT_W-1:0] status_i,
    input  logic [SLOT_W-1:0] adc_left_i,
    input  logic [SLOT_W-1:0] adc_right_i,
    output logic              sdout_o
);
    logic [SLOT_W-1:0] word_sel, aligned, sh;

    always_comb begin
        unique case (slot_i)
            SL_LEFT:  word_sel = adc_left_i;
            SL_RIGHT: word_sel = adc_right_i;
            default:  word_sel = status_i;
        endcase
        // shifting up drops the bits above the word length
        aligned = word_sel << (SLOT_W - int'(wbits_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            sdout_o <= 1'b0;
        end else if (load_i) begin
            sdout_o <= aligned[SLOT_W-1];
            sh      <= aligned << 1;
        end else if (shift_i) begin
            sdout_o <= sh[SLOT_W-1];
            sh      <= sh << 1;
        end else if (fall_i) begin
            sdout_o <= 1'b0;
        end
    end

    // R7: the line moves only after a falling bit-clock edge
    a_r7_sdout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sdout_o));
    // R5: outside a word the line is driven low
    a_r5_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !load_i && !shift_i) |=> !sdout_o);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import sap_pkg::*;
#(
    parameter int SLOT_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              wsync_i,
    input  logic              sdin_i,
    input  logic              mode_i,
    input  logic [1:0]        wlen_i,
    input  logic [SLOT_W-1:0] adc_left_i,
    input  logic [SLOT_W-1:0] adc_right_i,
    input  logic [SLOT_W-1:0] status_i,
    output logic              sdout_o,
    output logic [SLOT_W-1:0] dac_left_o,
    output logic [SLOT_W-1:0] dac_right_o,
    output logic [SLOT_W-1:0] ctrl_o,
    output logic              dac_valid_o
);
    // SLOT_W must be at least 24 so that every word length fits a slot
    logic       rise, fall, ws_s, sd_s;
    logic       cap, done, wbegin, load, shift;
    logic       dsp;
    logic [4:0] wbits;
    sap_slot_e  slot;

    assign dsp   = (mode_i == MODE_DSP);
    assign wbits = wlen_bits(wlen_i);

    sap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bclk_i(bclk_i), .ws_i(wsync_i), .sd_i(sdin_i),
        .rise_o(rise), .fall_o(fall), .ws_o(ws_s), .sd_o(sd_s)
    );

    sap_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rise_i(rise), .fall_i(fall), .ws_i(ws_s), .dsp_i(dsp),
        .wbits_i(wbits), .slot_o(slot), .cap_o(cap), .done_o(done),
        .begin_o(wbegin), .load_o(load), .shift_o(shift)
    );

    sap_rx #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cap_i(cap), .done_i(done), .begin_i(wbegin), .sd_i(sd_s),
        .slot_i(slot), .wbits_i(wbits),
        .dac_left_o(dac_left_o), .dac_right_o(dac_right_o),
        .ctrl_o(ctrl_o), .valid_o(dac_valid_o)
    );

    sap_tx #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .fall_i(fall), .load_i(load), .shift_i(shift), .slot_i(slot),
        .wbits_i(wbits), .status_i(status_i), .adc_left_i(adc_left_i),
        .adc_right_i(adc_right_i), .sdout_o(sdout_o)
    );

endmodule

// File: tb/audio_serial_port_bench.sv
`timescale 1ns/1ps
module audio_serial_port_bench;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n, bclk, wsel, sdin, mode;
    logic [1:0]    wlen;
    logic [SW-1:0] adcl, adcr, stat;
    logic          sdout_o, dac_valid_o;
    logic [SW-1:0] dac_left_o, dac_right_o, ctrl_o;

    int checks = 0, errors = 0, vcount = 0, r7bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    audio_serial_port u_audio_serial_port (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wsync_i(wsel), .sdin_i(sdin),
        .mode_i(mode), .wlen_i(wlen), .adc_left_i(adcl), .adc_right_i(adcr),
        .status_i(stat), .sdout_o(sdout_o), .dac_left_o(dac_left_o),
        .dac_right_o(dac_right_o), .ctrl_o(ctrl_o), .dac_valid_o(dac_valid_o)
    );

    always @(negedge clk) if (rst_n && dac_valid_o) vcount++;

    function automatic int wl(input logic [1:0] c);
        return (c == 2'b00) ? 16 : (c == 2'b01) ? 18 : (c == 2'b10) ? 20 : 24;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bit clock: drive on the falling edge, sample the port before the rise
    task automatic do_bit(input logic ws, input logic sd, output logic so);
        logic late;
        bclk = 1'b0; wsel = ws; sdin = sd;
        #40;
        so = sdout_o;
        bclk = 1'b1;
        #35;
        late = sdout_o;
        if (late !== so) r7bad++;
        #5;
    endtask

    task automatic t_reset();
        check("R1 sdout", {31'd0, sdout_o}, 32'd0);
        check("R1 left", {8'd0, dac_left_o}, 32'd0);
        check("R1 right", {8'd0, dac_right_o}, 32'd0);
        check("R1 ctrl", {8'd0, ctrl_o}, 32'd0);
        check("R1 strobe", vcount, 0);
    endtask

    task automatic dsp_frame(input logic [1:0] code, input logic [23:0] ctl, input logic [23:0] l,
                             input logic [23:0] r, input logic [23:0] st_w, input logic [23:0] al,
                             input logic [23:0] ar, input logic padv, input string tag);
        int w, padbad, v0, r7_0;
        logic [23:0] mask, word, rprev;
        logic [23:0] got [3];
        logic so, sd;
        w = wl(code); mask = 24'((32'd1 << w) - 1);
        padbad = 0; r7_0 = r7bad;
        wlen = code; stat = st_w; adcl = al; adcr = ar; mode = 1'b0;
        for (int s = 0; s < 3; s++) got[s] = '0;
        v0 = vcount; rprev = dac_right_o;
        do_bit(1'b1, 1'b0, so);
        for (int s = 0; s < 3; s++) begin
            word = (s == 0) ? ctl : (s == 1) ? l : r;
            for (int p = 0; p < SW; p++) begin
                sd = (p < w) ? word[w-1-p] : padv;
                if (s == 2 && p == w - 1) begin
                    check({"R8 no early update ", tag}, {8'd0, dac_right_o}, {8'd0, rprev});
                    check({"R8 no early strobe ", tag}, vcount - v0, 0);
                end
                do_bit(1'b0, sd, so);
                if (p < w) got[s] = {got[s][22:0], so};
                else if (so !== 1'b0) padbad++;
            end
        end
        do_bit(1'b0, 1'b0, so);
        do_bit(1'b0, 1'b0, so);
        check({"R2 ctrl ", tag}, {8'd0, ctrl_o}, {8'd0, ctl & mask});
        check({"R2 left ", tag}, {8'd0, dac_left_o}, {8'd0, l & mask});
        check({"R4 right ", tag}, {8'd0, dac_right_o}, {8'd0, r & mask});
        check({"R3 status ", tag}, {8'd0, got[0]}, {8'd0, st_w & mask});
        check({"R3 adc left ", tag}, {8'd0, got[1]}, {8'd0, al & mask});
        check({"R4 adc right ", tag}, {8'd0, got[2]}, {8'd0, ar & mask});
        check({"R5 pad low ", tag}, padbad, 0);
        check({"R8 one strobe ", tag}, vcount - v0, 1);
        check({"R7 edges ", tag}, r7bad - r7_0, 0);
    endtask

    task automatic i2s_frame(input logic [1:0] code, input int h, input logic [23:0] l,
                             input logic [23:0] r, input logic [23:0] al, input logic [23:0] ar,
                             input string tag);
        int w, padbad, v0, r7_0, pos;
        logic [23:0] mask, word, rprev, cprev, gl, gr;
        logic so, sd, isl;
        w = wl(code); mask = 24'((32'd1 << w) - 1);
        padbad = 0; r7_0 = r7bad; gl = '0; gr = '0;
        wlen = code; adcl = al; adcr = ar;
        v0 = vcount; rprev = dac_right_o; cprev = ctrl_o;
        for (int c = 0; c <= 2 * h; c++) begin
            isl  = (c <= h);
            pos  = isl ? c - 1 : c - h - 1;
            word = isl ? l : r;
            sd   = (c == 0) ? 1'b0 : (pos < w) ? word[w-1-pos] : 1'b1;
            if (c == h + w) begin
                check({"R8 no early update ", tag}, {8'd0, dac_right_o}, {8'd0, rprev});
                check({"R8 no early strobe ", tag}, vcount - v0, 0);
            end
            do_bit((c >= h), sd, so);
            if (c > 0) begin
                if (pos >= w) begin
                    if (so !== 1'b0) padbad++;
                end else if (isl) gl = {gl[22:0], so};
                else gr = {gr[22:0], so};
            end
        end
        do_bit(1'b1, 1'b0, so);
        do_bit(1'b1, 1'b0, so);
        check({"R6 left ", tag}, {8'd0, dac_left_o}, {8'd0, l & mask});
        check({"R6 right ", tag}, {8'd0, dac_right_o}, {8'd0, r & mask});
        check({"R6 adc left ", tag}, {8'd0, gl}, {8'd0, al & mask});
        check({"R6 adc right ", tag}, {8'd0, gr}, {8'd0, ar & mask});
        check({"R9 ctrl kept ", tag}, {8'd0, ctrl_o}, {8'd0, cprev});
        check({"R5 pad ", tag}, padbad, 0);
        check({"R8 one strobe ", tag}, vcount - v0, 1);
        check({"R7 edges ", tag}, r7bad - r7_0, 0);
    endtask

    task automatic t_enter_i2s();
        logic so;
        mode = 1'b1;
        do_bit(1'b1, 1'b0, so);
        do_bit(1'b1, 1'b0, so);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bclk = 1'b1; wsel = 1'b0; sdin = 1'b0; mode = 1'b0;
        wlen = 2'b11; adcl = '0; adcr = '0; stat = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        // R2 R3 full-width DSP frame
        dsp_frame(2'b11, 24'hA5C3F1, 24'h123456, 24'hFEDCBA, 24'h0F0F0F, 24'h8001FE, 24'h7F00A1, 1'b0, "dsp24");
        // R4 R5 short words with ones driven in the pad positions
        dsp_frame(2'b00, 24'h00BEEF, 24'h00C0DE, 24'h008421, 24'h00F00D, 24'h00ACE1, 24'h005A5A, 1'b1, "dsp16");
        // R4 upper parallel bits set but not sent
        dsp_frame(2'b01, 24'hFFFFFF, 24'h2AAAAA, 24'h155555, 24'hFC0003, 24'hFFFFFF, 24'hF3FFF1, 1'b1, "dsp18");
        dsp_frame(2'b10, 24'h0ABCDE, 24'h0FEDCB, 24'h080001, 24'h012345, 24'hE98765, 24'h0C0C0C, 1'b0, "dsp20");
        // R6 R9 I2S with long half-frames
        t_enter_i2s();
        i2s_frame(2'b11, 32, 24'h3C3C3C, 24'hC3C3C3, 24'h99AA55, 24'h0055FF, "i2s24h32");
        // R10 word end and new start on the same edge
        i2s_frame(2'b00, 16, 24'h00F731, 24'h001ABC, 24'h008000, 24'h00FFFF, "i2s16h16");
        i2s_frame(2'b10, 20, 24'h0E1F2A, 24'h07B3C5, 24'h0A0A0A, 24'h0F0001, "i2s20h20");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule